// File: doc/BRIEF.md
# Sleep and Idle Power-Mode Controller

This block sequences a small controller between three operating states: run, idle and sleep. A one-cycle sleep command moves it out of run. The idle-enable input chooses the destination. In idle only the CPU clock is stopped. In sleep the CPU clock, the peripheral clock and the primary and fast internal oscillators are all turned off, and the start-up status flag is cleared.

The two-bit clock-select field is captured only when a sleep command is accepted, and no wake-up ever changes it. The field encodes:
- 00: primary crystal
- 01: primary with PLL
- 10: fast internal oscillator (the reset default)
- 11: low-frequency internal oscillator

A wake-up comes from an interrupt or a watchdog time-out; reset also ends either low-power state. When the captured source is the primary oscillator and that oscillator is not already running, the controller enters a start-up state. That state counts `OST_TICKS` primary-oscillator ticks. For the PLL source it then waits `PLL_LOCK_CYC` reference-clock cycles. Only after that does it set the start-up flag and release the clocks. With two-speed start-up enabled, the core runs from the fast internal oscillator during the start-up state.

Mode encoding on `mode`: 00 run, 01 idle, 10 sleep, 11 start-up.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode is run (00), the captured select is 10, the start-up flag is 0, CPU and peripheral clock enables are 1, the fast internal oscillator enable is 1 and the primary oscillator enable is 0.
- R2: A sleep command in run with idle-enable 0 and no wake gives sleep mode (10) on the next cycle. CPU clock, peripheral clock, primary and fast internal oscillator enables are then 0, and the start-up flag is 0.
- R3: A sleep command in run with idle-enable 1 and no wake gives idle mode (01). The CPU clock enable is 0, the peripheral clock enable is 1, the start-up flag keeps its value, and the oscillator named by the captured select stays enabled.
- R4: `clk_sel` is captured into `active_sel` only by an accepted sleep command. Select changes at other times have no effect, and no wake-up changes `active_sel`.
- R5: The low-frequency oscillator enable is 1 whenever the watchdog is enabled, in every mode. It is also 1 when the captured select is 11, except in sleep. The secondary oscillator enable follows its request in every mode.
- R6: Idle and sleep are left only by an interrupt or watchdog wake (or reset). A sleep command in idle, sleep or start-up has no effect.
- R7: A wake to an internal source (select 1x) returns to run on the next cycle with the start-up flag at 0.
- R8: A wake with select 00 enters start-up (11) with the primary oscillator enabled. The controller returns to run after exactly `OST_TICKS` primary ticks, and the start-up flag rises on that same transition.
- R9: With select 01 the start-up state additionally lasts `PLL_LOCK_CYC` reference cycles after the tick count completes.
- R10: In start-up, CPU clock, peripheral clock and fast internal oscillator enables equal the two-speed enable.
- R11: A wake from idle with a primary select while the start-up flag is 1 returns to run on the next cycle without a start-up count.
- R12: A wake in the same cycle as a sleep command keeps the controller in run, and the select is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| rst_n | input | 1 | Active-low reset (also a wake source) |
| sleep_cmd | input | 1 | One-cycle sleep instruction strobe |
| idle_en | input | 1 | 1 selects idle, 0 selects sleep |
| clk_sel | input | 2 | Requested clock source |
| wake_irq | input | 1 | Interrupt wake request |
| wake_wdt | input | 1 | Watchdog time-out wake request |
| wdt_en | input | 1 | Watchdog enabled |
| sec_osc_req | input | 1 | Secondary timer oscillator requested |
| pri_tick | input | 1 | One pulse per primary oscillator period |
| two_speed_en | input | 1 | Run from internal oscillator during start-up |
| cpu_clk_en | output | 1 | CPU clock gate |
| per_clk_en | output | 1 | Peripheral clock gate |
| pri_osc_en | output | 1 | Primary oscillator enable |
| int_osc_en | output | 1 | Fast internal oscillator enable |
| lf_osc_en | output | 1 | Low-frequency oscillator enable |
| sec_osc_en | output | 1 | Secondary oscillator enable |
| osts | output | 1 | Primary clock is supplying the device |
| mode | output | 2 | Current mode |
| active_sel | output | 2 | Captured clock select |

## Verification
The bench aims at the exact length of start-up. A count that is off by one would show run one cycle early or late, and a missing PLL phase would release the clocks after the tick count alone. It drives wake and sleep in the same cycle; a design without that priority would drop into a low-power mode with no wake pending. It changes the select outside a sleep command and wakes from idle with the primary already running. A design that captures the select at the wrong time would report a new source, and one without the fast path would start a needless count. A random phase checks every output each cycle against a reference model, which catches a leaked CPU enable in idle or a stale start-up flag.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
    typedef enum logic [1:0] {
        MODE_RUN     = 2'b00,
        MODE_IDLE    = 2'b01,
        MODE_SLEEP   = 2'b10,
        MODE_STARTUP = 2'b11
    } mode_e;

    localparam logic [1:0] SEL_XTAL = 2'b00;
    localparam logic [1:0] SEL_PLL  = 2'b01;
    localparam logic [1:0] SEL_INT  = 2'b10;
    localparam logic [1:0] SEL_LF   = 2'b11;
    localparam logic [1:0] SEL_RESET = SEL_INT;

    typedef struct packed {
        mode_e      mode;
        logic [1:0] sel;
        logic       osts;
    } ctrl_st_t;

    function automatic logic is_primary(input logic [1:0] sel);
        return !sel[1];
    endfunction
endpackage

// File: rtl/pwr_startup_timer.sv
module pwr_startup_timer #(
    parameter int OST_TICKS    = 1024,
    parameter int PLL_LOCK_CYC = 96000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic pll_sel,
    input  logic pri_tick,
    output logic done
);
    localparam int OST_W  = $clog2(OST_TICKS + 1);
    localparam int LOCK_W = $clog2(PLL_LOCK_CYC + 1);
    localparam logic [OST_W-1:0]  OST_LAST  = OST_W'(OST_TICKS - 1);
    localparam logic [LOCK_W-1:0] LOCK_LAST = LOCK_W'(PLL_LOCK_CYC - 1);

    typedef struct packed {
        logic [OST_W-1:0]  ost_cnt;
        logic [LOCK_W-1:0] lock_cnt;
        logic              in_lock;
    } tmr_t;

    tmr_t t_d, t_q;
    logic done_d;

    always_comb begin
        t_d    = t_q;
        done_d = 1'b0;
        if (!active) begin
            t_d = '0;
        end else if (!t_q.in_lock) begin
            if (pri_tick) begin
                if (t_q.ost_cnt == OST_LAST) begin
                    if (pll_sel) begin
                        t_d.in_lock  = 1'b1;
                        t_d.lock_cnt = '0;
                    end else begin
                        done_d = 1'b1;
                    end
                end else begin
                    t_d.ost_cnt = t_q.ost_cnt + 1'b1;
                end
            end
        end else begin
            if (t_q.lock_cnt == LOCK_LAST) begin
                done_d = 1'b1;
            end else begin
                t_d.lock_cnt = t_q.lock_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign done = done_d;

    assert_lock_only_pll_R9: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.in_lock |-> pll_sel);
    assert_ost_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.ost_cnt <= OST_LAST);
endmodule

// File: rtl/pwr_clk_decode.sv
module pwr_clk_decode
    import pwr_mode_pkg::*;
(
    input  mode_e      mode,
    input  logic [1:0] sel,
    input  logic       two_speed_en,
    input  logic       wdt_en,
    input  logic       sec_osc_req,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       pri_osc_en,
    output logic       int_osc_en,
    output logic       lf_osc_en,
    output logic       sec_osc_en
);
    logic in_run, in_idle, in_sleep, in_su;

    always_comb begin
        in_run   = (mode == MODE_RUN);
        in_idle  = (mode == MODE_IDLE);
        in_sleep = (mode == MODE_SLEEP);
        in_su    = (mode == MODE_STARTUP);

        cpu_clk_en = in_run || (in_su && two_speed_en);
        per_clk_en = in_run || in_idle || (in_su && two_speed_en);
        pri_osc_en = is_primary(sel) && !in_sleep;
        int_osc_en = ((sel == SEL_INT) && !in_sleep) || (in_su && two_speed_en);
        lf_osc_en  = wdt_en || ((sel == SEL_LF) && !in_sleep);
        sec_osc_en = sec_osc_req;
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int OST_TICKS    = 1024,
    parameter int PLL_LOCK_CYC = 96000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_cmd,
    input  logic       idle_en,
    input  logic [1:0] clk_sel,
    input  logic       wake_irq,
    input  logic       wake_wdt,
    input  logic       wdt_en,
    input  logic       sec_osc_req,
    input  logic       pri_tick,
    input  logic       two_speed_en,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       pri_osc_en,
    output logic       int_osc_en,
    output logic       lf_osc_en,
    output logic       sec_osc_en,
    output logic       osts,
    output logic [1:0] mode,
    output logic [1:0] active_sel
);
    ctrl_st_t s_d, s_q;
    logic wake_any;
    logic su_done;

    assign wake_any = wake_irq || wake_wdt;

    pwr_startup_timer #(
        .OST_TICKS    (OST_TICKS),
        .PLL_LOCK_CYC (PLL_LOCK_CYC)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (s_q.mode == MODE_STARTUP),
        .pll_sel  (s_q.sel == SEL_PLL),
        .pri_tick (pri_tick),
        .done     (su_done)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.mode)
            MODE_RUN: begin
                if (sleep_cmd && !wake_any) begin
                    s_d.sel = clk_sel;
                    if (idle_en) begin
                        s_d.mode = MODE_IDLE;
                    end else begin
                        s_d.mode = MODE_SLEEP;
                        s_d.osts = 1'b0;
                    end
                end
            end
            MODE_IDLE, MODE_SLEEP: begin
                if (wake_any) begin
                    if (is_primary(s_q.sel) && !(s_q.mode == MODE_IDLE && s_q.osts)) begin
                        s_d.mode = MODE_STARTUP;
                    end else begin
                        s_d.mode = MODE_RUN;
                        if (!is_primary(s_q.sel)) s_d.osts = 1'b0;
                    end
                end
            end
            MODE_STARTUP: begin
                if (su_done) begin
                    s_d.mode = MODE_RUN;
                    s_d.osts = 1'b1;
                end
            end
            default: s_d = s_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mode <= MODE_RUN;
            s_q.sel  <= SEL_RESET;
            s_q.osts <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    pwr_clk_decode u_decode (
        .mode         (s_q.mode),
        .sel          (s_q.sel),
        .two_speed_en (two_speed_en),
        .wdt_en       (wdt_en),
        .sec_osc_req  (sec_osc_req),
        .cpu_clk_en   (cpu_clk_en),
        .per_clk_en   (per_clk_en),
        .pri_osc_en   (pri_osc_en),
        .int_osc_en   (int_osc_en),
        .lf_osc_en    (lf_osc_en),
        .sec_osc_en   (sec_osc_en)
    );

    assign osts       = s_q.osts;
    assign mode       = s_q.mode;
    assign active_sel = s_q.sel;

    assert_sleep_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SLEEP) |-> (!cpu_clk_en && !per_clk_en && !pri_osc_en && !osts));
    assert_idle_cpu_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_IDLE) |-> (!cpu_clk_en && per_clk_en));
    assert_sel_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode != MODE_RUN) |=> $stable(active_sel));
    assert_exit_needs_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.mode == MODE_IDLE || s_q.mode == MODE_SLEEP) && !wake_any) |=> $stable(mode));
    assert_startup_pri_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STARTUP) |-> pri_osc_en);
    assert_osts_from_startup_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MODE_STARTUP && s_d.osts) |=> (mode == MODE_RUN && osts));
    assert_two_speed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STARTUP) |-> (cpu_clk_en == two_speed_en && int_osc_en == two_speed_en));
    assert_wake_priority_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MODE_RUN && sleep_cmd && wake_any) |=> (mode == MODE_RUN && $stable(active_sel)));
endmodule

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
    localparam int OST  = 8;
    localparam int LOCK = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_cmd = 0, idle_en = 0, wake_irq = 0, wake_wdt = 0;
    logic wdt_en = 0, sec_osc_req = 0, pri_tick = 0, two_speed_en = 0;
    logic [1:0] clk_sel = 2'b00;
    logic cpu_clk_en, per_clk_en, pri_osc_en, int_osc_en, lf_osc_en, sec_osc_en, osts;
    logic [1:0] mode, active_sel;

    int n_tests = 0;
    int n_fail  = 0;

    // reference model state
    logic [1:0] m_mode, m_sel;
    logic m_osts, m_lock;
    int m_cnt, m_lcnt;

    always #10 clk = ~clk;

    pwr_mode_ctrl #(.OST_TICKS(OST), .PLL_LOCK_CYC(LOCK)) u_pwr_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_cmd(sleep_cmd), .idle_en(idle_en),
        .clk_sel(clk_sel), .wake_irq(wake_irq), .wake_wdt(wake_wdt), .wdt_en(wdt_en),
        .sec_osc_req(sec_osc_req), .pri_tick(pri_tick), .two_speed_en(two_speed_en),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .pri_osc_en(pri_osc_en),
        .int_osc_en(int_osc_en), .lf_osc_en(lf_osc_en), .sec_osc_en(sec_osc_en),
        .osts(osts), .mode(mode), .active_sel(active_sel)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_mode = 2'b00; m_sel = 2'b10; m_osts = 0; m_lock = 0; m_cnt = 0; m_lcnt = 0;
    endtask

    task automatic model_step();
        logic wk;
        wk = wake_irq | wake_wdt;
        case (m_mode)
            2'b00: if (sleep_cmd && !wk) begin
                m_sel = clk_sel;
                if (idle_en) m_mode = 2'b01;
                else begin m_mode = 2'b10; m_osts = 0; end
            end
            2'b01, 2'b10: if (wk) begin
                if (!m_sel[1] && !(m_mode == 2'b01 && m_osts)) begin
                    m_mode = 2'b11; m_cnt = 0; m_lock = 0; m_lcnt = 0;
                end else begin
                    m_mode = 2'b00;
                    if (m_sel[1]) m_osts = 0;
                end
            end
            default: begin
                if (!m_lock) begin
                    if (pri_tick) begin
                        if (m_cnt == OST - 1) begin
                            if (m_sel == 2'b01) begin m_lock = 1; m_lcnt = 0; end
                            else begin m_mode = 2'b00; m_osts = 1; end
                        end else m_cnt++;
                    end
                end else if (m_lcnt == LOCK - 1) begin
                    m_mode = 2'b00; m_osts = 1;
                end else m_lcnt++;
            end
        endcase
    endtask

    function automatic logic exp_cpu();
        return (m_mode == 2'b00) || (m_mode == 2'b11 && two_speed_en);
    endfunction
    function automatic logic exp_per();
        return (m_mode == 2'b00) || (m_mode == 2'b01) || (m_mode == 2'b11 && two_speed_en);
    endfunction
    function automatic logic exp_pri();
        return !m_sel[1] && (m_mode != 2'b10);
    endfunction
    function automatic logic exp_int();
        return (m_sel == 2'b10 && m_mode != 2'b10) || (m_mode == 2'b11 && two_speed_en);
    endfunction
    function automatic logic exp_lf();
        return wdt_en || (m_sel == 2'b11 && m_mode != 2'b10);
    endfunction

    task automatic compare_all();
        check("R6 mode", mode, m_mode);
        check("R4 active_sel", active_sel, m_sel);
        check("R8 osts", osts, m_osts);
        check("R2 cpu_clk_en", cpu_clk_en, exp_cpu());
        check("R3 per_clk_en", per_clk_en, exp_per());
        check("R8 pri_osc_en", pri_osc_en, exp_pri());
        check("R10 int_osc_en", int_osc_en, exp_int());
        check("R5 lf_osc_en", lf_osc_en, exp_lf());
        check("R5 sec_osc_en", sec_osc_en, sec_osc_req);
    endtask

    // one clock: model follows inputs at the edge, outputs compared 5 ns later
    task automatic cyc();
        @(posedge clk);
        model_step();
        #5;
        compare_all();
    endtask

    task automatic clear_in();
        sleep_cmd = 0; wake_irq = 0; wake_wdt = 0; pri_tick = 0;
    endtask

    task automatic go_sleep(input logic idle, input logic [1:0] sel);
        sleep_cmd = 1; idle_en = idle; clk_sel = sel;
        cyc();
        clear_in();
    endtask

    task automatic wake();
        wake_irq = 1;
        cyc();
        clear_in();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int dur;
        model_reset();
        #15;
        // R1: reset state
        check("R1 mode", mode, 0);
        check("R1 active_sel", active_sel, 2);
        check("R1 osts", osts, 0);
        check("R1 cpu", cpu_clk_en, 1);
        check("R1 int_osc", int_osc_en, 1);
        check("R1 pri_osc", pri_osc_en, 0);
        rst_n = 1;
        cyc(); cyc();

        // R4: select changes outside a sleep command have no effect
        clk_sel = 2'b01; cyc(); cyc();
        check("R4 sel ignored in run", active_sel, 2);

        // R12: wake together with sleep command
        sleep_cmd = 1; wake_wdt = 1; clk_sel = 2'b00; cyc(); clear_in();
        check("R12 stays run", mode, 0);
        check("R12 sel not captured", active_sel, 2);

        // R2 / R7: sleep on internal, wake back to run
        wdt_en = 1;
        go_sleep(0, 2'b10);
        check("R2 sleep mode", mode, 2);
        check("R2 cpu off", cpu_clk_en, 0);
        check("R5 lf kept by watchdog", lf_osc_en, 1);
        // R6: sleep command in sleep ignored
        sleep_cmd = 1; idle_en = 1; cyc(); clear_in();
        check("R6 sleep cmd ignored", mode, 2);
        wake();
        check("R7 run after wake", mode, 0);
        wdt_en = 0;

        // R8: crystal start-up, exact tick count
        go_sleep(0, 2'b00);
        wake();
        check("R8 start-up entered", mode, 3);
        check("R10 cpu off without two-speed", cpu_clk_en, 0);
        dur = 0;
        pri_tick = 1;
        while (mode == 2'b11 && dur < 100) begin cyc(); dur++; end
        pri_tick = 0;
        check("R8 start-up length", dur, OST);
        check("R8 osts set", osts, 1);

        // R11: idle with primary running, fast wake
        go_sleep(1, 2'b00);
        check("R3 idle mode", mode, 1);
        check("R3 osts kept", osts, 1);
        clk_sel = 2'b10; cyc();
        wake_wdt = 1; cyc(); clear_in();
        check("R11 fast return", mode, 0);
        check("R4 wake keeps sel", active_sel, 0);

        // R9 / R10: PLL start-up with two-speed
        two_speed_en = 1;
        go_sleep(0, 2'b01);
        wake();
        check("R10 cpu on in two-speed", cpu_clk_en, 1);
        dur = 0;
        pri_tick = 1;
        while (mode == 2'b11 && dur < 100) begin cyc(); dur++; end
        pri_tick = 0;
        check("R9 pll start-up length", dur, OST + LOCK);
        two_speed_en = 0;

        // random phase
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 4000; i++) begin
            sleep_cmd    = ($urandom_range(7) == 0);
            wake_irq     = ($urandom_range(15) == 0);
            wake_wdt     = ($urandom_range(31) == 0);
            idle_en      = $urandom_range(1);
            clk_sel      = 2'($urandom_range(3));
            pri_tick     = $urandom_range(1);
            if ($urandom_range(63) == 0) two_speed_en = ~two_speed_en;
            if ($urandom_range(63) == 0) wdt_en = ~wdt_en;
            if ($urandom_range(31) == 0) sec_osc_req = ~sec_osc_req;
            cyc();
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule